// File: doc/BRIEF.md
# Monochrome Bitmap to Brightness Framebuffer Writer

This block turns a bit-packed one-bit-per-pixel image into writes to an 8-bit-per-pixel framebuffer for a small LED panel. A write command gives a target origin, a rectangle width and height, and a pitch, which is the number of bits each source row occupies. The bytes then arrive on a valid/ready stream. Each lit source bit stores the current global brightness in the framebuffer, and each dark bit stores zero. Any bits left over after the last useful bit of a command are dropped, and the next command starts on a fresh byte.

A second command sets a new global brightness. The block works out the signed step from the old level to the new one. It then walks the whole framebuffer through a read port and a write port, shifts every nonzero pixel by that step, and clamps the result so a lit pixel never goes dark or overflows. Pixels that hold zero are not written.

The controller is a single state machine with these states:
- ST_IDLE: waits for a command and is the only state that accepts one.
- ST_ERR: one-cycle error response. Entered from ST_IDLE when a rejected write is accepted.
- ST_FIN: one-cycle completion response. Entered from ST_IDLE for an empty write (no rows or zero pitch). Entered from ST_BITS after the last bit of the last row. Entered from ST_WB after the last pixel.
- ST_FETCH: requests a stream byte. Entered from ST_IDLE at the start of a write, or from ST_BITS when the held byte runs out.
- ST_BITS: consumes one bit per cycle. Entered from ST_FETCH when a byte is taken.
- ST_RD: issues a framebuffer read. Entered from ST_IDLE at the start of a brightness change, or from ST_WB for the next pixel.
- ST_WB: writes back the rescaled pixel. Always follows ST_RD.

Both ST_ERR and ST_FIN return to ST_IDLE.

Top module: `bmp_fb_writer`

## Requirements
- R1: A write whose x is at least the panel width, whose y is at least the panel height, whose x+width exceeds the panel width, or whose y+height exceeds the panel height gives a one-cycle `err` pulse. It makes no framebuffer write and takes no stream byte.
- R2: A write whose pitch is smaller than its width is rejected in the same way as in R1.
- R3: Within each stream byte, bits are used starting at bit 0 and moving upward. A new byte is requested only once all 8 bits of the held byte are used, so a write takes exactly ceil(height×pitch/8) bytes.
- R4: Each source row occupies pitch bits. The first width bits are pixels, and the remaining pitch−width bits are discarded. These discarded bits include those after the last row. The next row starts at the following bit, with no byte realignment.
- R5: The source bit at row r, column c goes to framebuffer address (y+r)×panel_width+(x+c). A 1 stores the current brightness there and a 0 stores 0. Addresses outside the rectangle are not written. `done` pulses for one cycle when the write is complete.
- R6: A brightness command (`cmd_op`=1) with value 0 sets the brightness to 1. Any other value is taken as given, so the level range is 1..255.
- R7: On a brightness command, (new − old) is added to every nonzero stored pixel and the result is clamped to 1..255. Zero pixels stay zero. `done` pulses when all pixels have been processed.
- R8: After reset, the brightness is 255.
- R9: `cmd_ready` is high only while the block is idle, so commands wait while a write or rescale runs. `done` and `err` are never high together. A write command is `cmd_op`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 1 | 0 = bitmap write, 1 = brightness change |
| cmd_x | input | CW | Rectangle origin column |
| cmd_y | input | CW | Rectangle origin row |
| cmd_w | input | CW | Rectangle width |
| cmd_h | input | CW | Rectangle height |
| cmd_pitch | input | CW | Source bits per row |
| cmd_level | input | BW | Requested brightness |
| s_valid | input | 1 | Stream byte present |
| s_ready | output | 1 | Stream byte taken when high with s_valid |
| s_data | input | 8 | Stream byte |
| fb_we | output | 1 | Framebuffer write enable |
| fb_waddr | output | AW | Framebuffer write address |
| fb_wdata | output | BW | Framebuffer write value |
| fb_re | output | 1 | Framebuffer read enable; data is expected on fb_rdata one cycle later |
| fb_raddr | output | AW | Framebuffer read address |
| fb_rdata | input | BW | Framebuffer read value |
| done | output | 1 | Command completed |
| err | output | 1 | Command rejected |

## Verification
The bench builds the block as a 5×5 panel with 4-bit coordinate fields and 8-bit levels. With these values, every origin and extent from 0 to 15 can be swept exhaustively along each axis, which covers every out-of-panel combination. It also sweeps every in-panel rectangle with pitches equal to, slightly above and well above the width. These pitches make rows straddle byte edges and make the trailing padding pull in extra bytes. A 25-pixel framebuffer keeps a full-memory comparison after each command cheap. Brightness steps to 0, 1, 255 and values in between reach both clamp limits on pixels holding a mix of levels.

// File: rtl/bmp_fb_pkg.sv
package bmp_fb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BITS,
        ST_RD,
        ST_WB,
        ST_FIN,
        ST_ERR
    } wr_state_t;

    localparam logic OP_WRITE = 1'b0;
    localparam logic OP_LEVEL = 1'b1;
endpackage

// File: rtl/bmp_req_check.sv
module bmp_req_check #(
    parameter int PANEL_W = 5,
    parameter int PANEL_H = 5,
    parameter int CW      = 4
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic [CW-1:0] pitch,
    output logic          bad,
    output logic          empty
);
    localparam logic [CW:0] PW_L = (CW+1)'(PANEL_W);
    localparam logic [CW:0] PH_L = (CW+1)'(PANEL_H);

    always_comb begin
        bad = ({1'b0, x} >= PW_L) || ({1'b0, y} >= PH_L) ||
              (({1'b0, x} + {1'b0, w}) > PW_L) ||
              (({1'b0, y} + {1'b0, h}) > PH_L) ||
              (pitch < w);
        empty = (h == '0) || (pitch == '0);
    end
endmodule

// File: rtl/bmp_bit_unpacker.sv
module bmp_bit_unpacker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       load,
    input  logic [7:0] byte_in,
    input  logic       shift,
    output logic       bit_out,
    output logic       last_bit
);
    logic [7:0] sh_q;
    logic [3:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= byte_in;
            cnt_q <= 4'd8;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 4'd1;
        end
    end

    assign bit_out  = sh_q[0];
    assign last_bit = (cnt_q == 4'd1);
endmodule

// File: rtl/bmp_level_clamp.sv
module bmp_level_clamp #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]        req_level,
    input  logic [BW-1:0]        cur_level,
    input  logic [BW-1:0]        pix_in,
    input  logic signed [BW:0]   delta_in,
    output logic [BW-1:0]        new_level,
    output logic signed [BW:0]   delta_out,
    output logic [BW-1:0]        pix_out
);
    localparam logic signed [BW+1:0] LO_S = (BW+2)'(1);
    localparam logic signed [BW+1:0] HI_S = {2'b00, {BW{1'b1}}};

    logic signed [BW+1:0] sum;

    always_comb begin
        new_level = (req_level == '0) ? BW'(1) : req_level;
        delta_out = $signed({1'b0, new_level}) - $signed({1'b0, cur_level});
        sum = $signed({2'b00, pix_in}) + $signed({delta_in[BW], delta_in});
        if (sum < LO_S)
            pix_out = BW'(1);
        else if (sum > HI_S)
            pix_out = {BW{1'b1}};
        else
            pix_out = sum[BW-1:0];
    end
endmodule

// File: rtl/bmp_fb_writer.sv
module bmp_fb_writer
    import bmp_fb_pkg::*;
#(
    parameter int PANEL_W = 5,
    parameter int PANEL_H = 5,
    parameter int CW      = 4,
    parameter int BW      = 8,
    localparam int NPIX   = PANEL_W * PANEL_H,
    localparam int AW     = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_op,
    input  logic [CW-1:0] cmd_x,
    input  logic [CW-1:0] cmd_y,
    input  logic [CW-1:0] cmd_w,
    input  logic [CW-1:0] cmd_h,
    input  logic [CW-1:0] cmd_pitch,
    input  logic [BW-1:0] cmd_level,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [7:0]    s_data,
    output logic          fb_we,
    output logic [AW-1:0] fb_waddr,
    output logic [BW-1:0] fb_wdata,
    output logic          fb_re,
    output logic [AW-1:0] fb_raddr,
    input  logic [BW-1:0] fb_rdata,
    output logic          done,
    output logic          err
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NPIX - 1);
    localparam logic [BW-1:0] LEVEL_RST = {BW{1'b1}};

    wr_state_t state_q, state_n;

    logic [CW-1:0] x_q, y_q, w_q, h_q, pitch_q, row_q, col_q;
    logic [BW-1:0] level_q;
    logic signed [BW:0] delta_q;
    logic [AW-1:0] idx_q;

    logic req_bad, req_empty;
    logic cur_bit, last_bit;
    logic [BW-1:0] new_level, pix_out;
    logic signed [BW:0] delta_new;
    logic accept, row_end, last_row;
    logic [CW:0] row_abs, col_abs;
    logic [AW-1:0] pix_addr;

    bmp_req_check #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CW(CW)) u_check (
        .x(cmd_x), .y(cmd_y), .w(cmd_w), .h(cmd_h), .pitch(cmd_pitch),
        .bad(req_bad), .empty(req_empty)
    );

    bmp_bit_unpacker u_unpack (
        .clk(clk), .rst_n(rst_n),
        .flush(accept),
        .load(state_q == ST_FETCH && s_valid),
        .byte_in(s_data),
        .shift(state_q == ST_BITS),
        .bit_out(cur_bit),
        .last_bit(last_bit)
    );

    bmp_level_clamp #(.BW(BW)) u_clamp (
        .req_level(cmd_level), .cur_level(level_q),
        .pix_in(fb_rdata), .delta_in(delta_q),
        .new_level(new_level), .delta_out(delta_new), .pix_out(pix_out)
    );

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign row_end  = (col_q == pitch_q - CW'(1));
    assign last_row = (row_q == h_q - CW'(1));
    assign row_abs  = {1'b0, y_q} + {1'b0, row_q};
    assign col_abs  = {1'b0, x_q} + {1'b0, col_q};
    assign pix_addr = AW'(row_abs) * AW'(PANEL_W) + AW'(col_abs);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
                if (cmd_op == OP_LEVEL) state_n = ST_RD;
                else if (req_bad)       state_n = ST_ERR;
                else if (req_empty)     state_n = ST_FIN;
                else                    state_n = ST_FETCH;
            end
            ST_FETCH: if (s_valid) state_n = ST_BITS;
            ST_BITS: begin
                if (row_end && last_row) state_n = ST_FIN;
                else if (last_bit)       state_n = ST_FETCH;
            end
            ST_RD:  state_n = ST_WB;
            ST_WB:  state_n = (idx_q == LAST_IDX) ? ST_FIN : ST_RD;
            ST_FIN: state_n = ST_IDLE;
            ST_ERR: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        s_ready   = 1'b0;
        fb_we     = 1'b0;
        fb_waddr  = idx_q;
        fb_wdata  = pix_out;
        fb_re     = 1'b0;
        fb_raddr  = idx_q;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE:  cmd_ready = 1'b1;
            ST_FETCH: s_ready = 1'b1;
            ST_BITS: begin
                fb_we    = (col_q < w_q);
                fb_waddr = pix_addr;
                fb_wdata = cur_bit ? level_q : '0;
            end
            ST_RD:  fb_re = 1'b1;
            ST_WB:  fb_we = (fb_rdata != '0);
            ST_FIN: done = 1'b1;
            ST_ERR: err = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0; y_q <= '0; w_q <= '0; h_q <= '0; pitch_q <= '0;
            row_q <= '0; col_q <= '0; idx_q <= '0;
            level_q <= LEVEL_RST;
            delta_q <= '0;
        end else if (accept) begin
            x_q <= cmd_x; y_q <= cmd_y; w_q <= cmd_w; h_q <= cmd_h;
            pitch_q <= cmd_pitch;
            row_q <= '0; col_q <= '0; idx_q <= '0;
            if (cmd_op == OP_LEVEL) begin
                level_q <= new_level;
                delta_q <= delta_new;
            end
        end else if (state_q == ST_BITS) begin
            if (row_end) begin
                col_q <= '0;
                row_q <= row_q + CW'(1);
            end else begin
                col_q <= col_q + CW'(1);
            end
        end else if (state_q == ST_WB) begin
            idx_q <= idx_q + AW'(1);
        end
    end
endmodule

// File: rtl/bmp_fb_writer_chk.sv
module bmp_fb_writer_chk #(
    parameter int PANEL_W = 5,
    parameter int PANEL_H = 5,
    parameter int CW      = 4,
    parameter int BW      = 8,
    localparam int NPIX   = PANEL_W * PANEL_H,
    localparam int AW     = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          cmd_op,
    input logic [CW-1:0] cmd_x,
    input logic [CW-1:0] cmd_w,
    input logic [CW-1:0] cmd_pitch,
    input logic          s_ready,
    input logic          fb_we,
    input logic [AW-1:0] fb_waddr,
    input logic [BW-1:0] fb_wdata,
    input logic          fb_re,
    input logic          done,
    input logic          err
);
    localparam logic [CW:0] PW_L = (CW+1)'(PANEL_W);
    localparam logic [AW:0] N_L  = (AW+1)'(NPIX);

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !fb_we); // R1
    AST_X_OUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_op && ({1'b0, cmd_x} >= PW_L) |=> err); // R1
    AST_PITCH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_op && (cmd_pitch < cmd_w) |=> err); // R2
    AST_ADDR_IN_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ({1'b0, fb_waddr} < N_L)); // R5
    AST_RESCALE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we && $past(fb_re) |-> fb_wdata != '0); // R7
    AST_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !cmd_ready); // R9
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R9
endmodule

bind bmp_fb_writer bmp_fb_writer_chk #(
    .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CW(CW), .BW(BW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_w(cmd_w), .cmd_pitch(cmd_pitch),
    .s_ready(s_ready), .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata),
    .fb_re(fb_re), .done(done), .err(err)
);

// File: tb/bmp_fb_writer_bench.sv
`timescale 1ns/100ps
module bmp_fb_writer_bench;
    localparam int PW = 5, PH = 5, CW = 4, BW = 8;
    localparam int N = PW * PH;
    localparam int AW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0;
    logic [CW-1:0] cmd_x = '0, cmd_y = '0, cmd_w = '0, cmd_h = '0, cmd_pitch = '0;
    logic [BW-1:0] cmd_level = '0;
    logic s_valid = 1'b1, s_ready;
    logic [7:0] s_data;
    logic fb_we, fb_re, done, err;
    logic [AW-1:0] fb_waddr, fb_raddr;
    logic [BW-1:0] fb_wdata, fb_rdata;

    logic [7:0] mem [N];
    logic [7:0] expm [N];
    logic [7:0] sbuf [256];
    int k, base, nchk = 0, nerr = 0, cyc = 0, bright_m = 255;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bmp_fb_writer #(.PANEL_W(PW), .PANEL_H(PH), .CW(CW), .BW(BW)) u_bmp_fb_writer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_pitch(cmd_pitch), .cmd_level(cmd_level), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .fb_we(fb_we), .fb_waddr(fb_waddr),
        .fb_wdata(fb_wdata), .fb_re(fb_re), .fb_raddr(fb_raddr), .fb_rdata(fb_rdata),
        .done(done), .err(err)
    );

    function automatic logic [7:0] preset(int i);
        return 8'(i * 9 + 3);
    endfunction

    function automatic bit pat(int i, int seed);
        if (seed < 0) return 1'b1;
        return ((i * 5 + seed * 3 + i / 3) % 7) < 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= preset(i);
            fb_rdata <= '0;
        end else begin
            if (fb_we) mem[fb_waddr] <= fb_wdata;
            if (fb_re) fb_rdata <= mem[fb_raddr];
        end
    end

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else if (s_valid && s_ready) k <= k + 1;
    end
    assign s_data = sbuf[8'(k - base)];

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    task automatic cmp_mem(string req);
        int bad = 0, first = -1;
        for (int i = 0; i < N; i++)
            if (mem[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(mem[first]), int'(expm[first]));
    endtask

    task automatic run_cmd(bit op, int x, int y, int w, int h, int p, int lvl,
                           output bit got_done, output bit got_err, output bit busy_ok);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_x = CW'(x); cmd_y = CW'(y); cmd_w = CW'(w); cmd_h = CW'(h);
        cmd_pitch = CW'(p); cmd_level = BW'(lvl); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_ok = 1; got_done = 0; got_err = 0;
        for (int n = 0; n < 3000; n++) begin
            if (done || err) begin
                got_done = done; got_err = err;
                break;
            end
            if (cmd_ready) busy_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic do_write(int x, int y, int w, int h, int p, int seed);
        bit d, e, b, ok;
        int total, nbytes;
        string rq;
        total = h * p;
        for (int i = 0; i < 256; i++) sbuf[i] = 8'h00;
        for (int i = 0; i < total; i++) sbuf[i / 8][i % 8] = pat(i, seed);
        @(negedge clk);
        base = k;
        ok = (x < PW) && (y < PH) && (x + w <= PW) && (y + h <= PH) && (p >= w);
        run_cmd(1'b0, x, y, w, h, p, 0, d, e, b);
        chk(b, "R9", int'(b), 1);
        if (ok) begin
            rq = (p > w) ? "R4" : "R5";
            chk(d && !e, "R5", int'(d), 1);
            for (int r = 0; r < h; r++)
                for (int c = 0; c < w; c++)
                    expm[(y + r) * PW + x + c] = pat(r * p + c, seed) ? 8'(bright_m) : 8'h00;
            nbytes = (total + 7) / 8;
            chk((k - base) == nbytes, (p > w) ? "R4" : "R3", k - base, nbytes);
            cmp_mem(rq);
        end else begin
            rq = (p < w) ? "R2" : "R1";
            chk(e && !d, rq, int'(e), 1);
            chk((k - base) == 0, rq, k - base, 0);
            cmp_mem(rq);
        end
    endtask

    task automatic do_level(int v);
        bit d, e, b;
        int nb, delta, t;
        nb = (v == 0) ? 1 : v;
        delta = nb - bright_m;
        bright_m = nb;
        for (int i = 0; i < N; i++)
            if (expm[i] != 0) begin
                t = int'(expm[i]) + delta;
                if (t < 1) t = 1;
                if (t > 255) t = 255;
                expm[i] = 8'(t);
            end
        run_cmd(1'b1, 0, 0, 0, 0, 0, v, d, e, b);
        chk(b && d && !e, "R7", int'(d), 1);
        cmp_mem(v == 0 ? "R6" : "R7");
    endtask

    initial begin
        int cnt;
        for (int i = 0; i < N; i++) expm[i] = preset(i);
        base = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1 && !done && !err && !s_ready && !fb_we, "R9",
            int'(cmd_ready), 1);
        cmp_mem("R9");

        // R8: first lit write uses reset brightness 255
        do_write(0, 0, PW, PH, PW, -1);
        chk(mem[12] == 8'd255, "R8", int'(mem[12]), 255);

        // R1: exhaustive horizontal and vertical extents
        for (int x = 0; x < 16; x++)
            for (int w = 0; w < 16; w++) do_write(x, 0, w, 1, w, x + w);
        for (int y = 0; y < 16; y++)
            for (int h = 0; h < 16; h++) do_write(0, y, 1, h, 1, y + h);

        // R2: pitch below width
        for (int w = 1; w <= PW; w++)
            for (int p = 0; p < w; p++) do_write(0, 0, w, 1, p, p);

        // R3 R4 R5: every in-panel rectangle, several pitches
        cnt = 0;
        for (int x = 0; x < PW; x++)
            for (int y = 0; y < PH; y++)
                for (int w = 0; w <= PW - x; w++)
                    for (int h = 0; h <= PH - y; h++) begin
                        int extra;
                        case ((x + y + w + h) % 3)
                            0: extra = 0;
                            1: extra = 3;
                            default: extra = 9;
                        endcase
                        do_write(x, y, w, h, w + extra, cnt);
                        cnt++;
                        if (cnt % 97 == 0) do_level(40 + cnt % 150);
                    end

        // R6 R7: brightness steps reaching both clamps
        do_level(0);
        do_write(2, 2, 1, 1, 1, -1);
        chk(mem[12] == 8'd1, "R6", int'(mem[12]), 1);
        do_level(255);
        do_level(1);
        do_level(200);
        do_write(0, 1, 5, 2, 7, 5);
        do_level(3);
        do_level(254);
        do_level(255);

        summary();
    end
endmodule